// File: doc/BRIEF.md
# Serial Byte-Pair Word Packer with Idle Sleep

This block sits behind a UART-style receiver and packs the bytes it delivers, two at a time, into 16-bit words for an external memory. When the second byte of a pair arrives, the block presents the finished word and raises a one-cycle valid strobe toward the memory controller.

The block also watches the raw serial line. Upstream framing, baud timing and bit recovery are handled elsewhere. If the line shows no start bit for a programmable number of clocks, the packing logic loses its functional enable and the block reports that it is asleep. This is how the block models a clock turned off to save power. A sleep indicator drives an LED and a status output for the power controller.

A falling edge on the synchronized line wakes the block. The synchronizer and the timer run on the always-on clock. Any byte that was only half packed when the block fell asleep is dropped.

Top module: `ser_word_packer`

## Requirements
- R1: A packed word carries the first accepted byte in bits 15:8 and the second accepted byte in bits 7:0.
- R2: `word_valid_o` is high for exactly one cycle, the cycle after the second byte of a pair is accepted. `word_o` changes only together with that strobe and holds its value otherwise.
- R3: `sleep_o` rises after `IDLE_CYCLES` consecutive rising clock edges without a detected falling edge on the line. This counts from reset or from the last detected falling edge.
- R4: `led_o` is high exactly when `sleep_o` is high.
- R5: While `sleep_o` is high, `byte_valid_i` is ignored: no strobe is produced and `word_o` does not change.
- R6: A high-to-low transition on `line_i` passes through a two-flop synchronizer and clears `sleep_o` on the third rising edge after `line_i` goes low. A line held low does not count as further activity.
- R7: Entering sleep discards a half-packed word. The first byte accepted after waking goes to bits 15:8.
- R8: After reset, `sleep_o`, `led_o`, `word_valid_o` and `word_o` are all zero, no byte is pending, and the idle count starts from zero.
- R9: Each detected falling edge restarts the idle count. Activity spaced by fewer than `IDLE_CYCLES` clocks keeps the block awake indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Always-on system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw serial receive line, idle high |
| byte_valid_i | input | 1 | A received byte is present on byte_i |
| byte_i | input | 8 | Received byte |
| word_valid_o | output | 1 | One-cycle strobe: word_o holds a new word |
| word_o | output | 16 | Packed word toward memory |
| sleep_o | output | 1 | Packing domain is switched off |
| led_o | output | 1 | Sleep indicator LED |

## Verification
The hardest situation to reach is a byte pair that is split across a sleep period. The first byte is accepted, the line then stays quiet until the timeout expires, and the second byte arrives only after a start bit has woken the block. The bench builds this case by sending a single byte and then holding the line high past the shortened timeout. It then wakes the block with a falling edge and sends a new pair, so the stale upper byte must not appear in the output. Separate sequences measure the exact wake latency from a falling edge and present bytes while the block is asleep.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    byte_t hi;
    byte_t lo;
  } word_s;
endpackage

// File: rtl/swp_line_sync.sv
module swp_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic fall_o
);
  // Chain plus one extra flop for edge detect; reset to idle-high.
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], line_i};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

  // R6
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/swp_idle_timer.sv
module swp_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 32'd375_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic activity_i,
  output logic asleep_o
);
  localparam int CNT_W = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             asleep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      asleep_q <= 1'b0;
    end else if (activity_i) begin
      cnt_q    <= '0;
      asleep_q <= 1'b0;
    end else if (!asleep_q) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q    <= '0;
        asleep_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign asleep_o = asleep_q;

  // R3
  sleep_at_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_q) |-> $past(cnt_q) == CNT_LAST);

  // R6
  wake_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_i |=> !asleep_q);

  // R9
  restart_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_i |=> cnt_q == '0);
endmodule

// File: rtl/swp_packer.sv
module swp_packer
  import swp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  byte_valid_i,
  input  byte_t byte_i,
  output logic  word_valid_o,
  output word_t word_o
);
  logic  half_q;
  byte_t hi_q;
  word_s word_q;
  logic  valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      hi_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!en_i) begin
        half_q <= 1'b0;  // sleeping drops a pending upper byte
      end else if (byte_valid_i) begin
        if (!half_q) begin
          hi_q   <= byte_i;
          half_q <= 1'b1;
        end else begin
          word_q  <= '{hi: hi_q, lo: byte_i};
          valid_q <= 1'b1;
          half_q  <= 1'b0;
        end
      end
    end
  end

  assign word_valid_o = valid_q;
  assign word_o       = word_q;

  // R2
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  // R2
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> word_valid_o);

  // R5
  no_strobe_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !word_valid_o);

  // R7
  drop_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !half_q);
endmodule

// File: rtl/ser_word_packer.sv
module ser_word_packer
  import swp_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 32'd375_000_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        line_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic        word_valid_o,
  output logic [15:0] word_o,
  output logic        sleep_o,
  output logic        led_o
);
  logic line_fall;
  logic asleep;

  swp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .fall_o (line_fall)
  );

  swp_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .activity_i (line_fall),
    .asleep_o   (asleep)
  );

  // Functional enable stands in for the gated clock of the packing domain.
  swp_packer u_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (~asleep),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .word_valid_o (word_valid_o),
    .word_o       (word_o)
  );

  assign sleep_o = asleep;
  assign led_o   = asleep;

  // R4
  led_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o == sleep_o);
endmodule

// File: tb/ser_word_packer_tb.sv
module ser_word_packer_tb;
  localparam int unsigned IDLE = 40;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b1;
  logic bv = 1'b0;
  logic [7:0] bdata = '0;
  logic word_valid;
  logic [15:0] word;
  logic sleep, led;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ser_word_packer #(.IDLE_CYCLES(IDLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line),
    .byte_valid_i(bv), .byte_i(bdata),
    .word_valid_o(word_valid), .word_o(word),
    .sleep_o(sleep), .led_o(led)
  );

  // Behavioural reference model
  bit   hist[$];
  int   m_idle;
  bit   m_sleep, m_half, m_valid;
  logic [7:0]  m_hi;
  logic [15:0] m_word;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{1'b1, 1'b1, 1'b1};
      m_idle = 0; m_sleep = 0; m_half = 0; m_valid = 0;
      m_hi = '0; m_word = '0;
    end else begin
      bit fall;
      bit was_sleep;
      cycles++;
      fall = hist[$-2] && !hist[$-1];
      hist.push_back(line);
      void'(hist.pop_front());
      was_sleep = m_sleep;
      m_valid = 0;
      if (was_sleep) m_half = 0;
      else if (bv) begin
        if (!m_half) begin m_hi = bdata; m_half = 1; end
        else begin m_word = {m_hi, bdata}; m_valid = 1; m_half = 0; end
      end
      if (fall) begin m_idle = 0; m_sleep = 0; end
      else if (!m_sleep) begin
        m_idle++;
        if (m_idle == IDLE) begin m_sleep = 1; m_idle = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(word_valid == m_valid, "R2 strobe", word_valid, m_valid);
      chk(word == m_word, "R1 word", word, m_word);
      chk(sleep == m_sleep, "R3 sleep", sleep, m_sleep);
      chk(led == sleep, "R4 led", led, sleep);
    end
  end

  always @(posedge clk) begin
    if (cycles >= WATCHDOG && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) line = 1'b0;
    @(negedge clk) line = 1'b1;
    repeat (2) @(negedge clk);
    bv = 1'b1; bdata = b;
    @(negedge clk) bv = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(sleep == 0 && led == 0 && word_valid == 0 && word == 0,
        "R8 reset", {sleep, led, word_valid, word}, 0);
    rst_n = 1'b1;

    // R1 framed pairs
    send_byte(8'hA5);
    send_byte(8'h3C);
    chk(word_valid == 1 && word == 16'hA53C, "R1 first pair", word, 16'hA53C);
    send_byte(8'h01);
    send_byte(8'hFE);
    chk(word == 16'h01FE, "R1 second pair", word, 16'h01FE);

    // R2 back-to-back bytes
    @(negedge clk) begin bv = 1; bdata = 8'h11; end
    @(negedge clk) bdata = 8'h22;
    @(negedge clk) bdata = 8'h33;
    chk(word_valid == 1 && word == 16'h1122, "R2 burst word", word, 16'h1122);
    @(negedge clk) bdata = 8'h44;
    chk(word_valid == 0, "R2 single-cycle strobe", word_valid, 0);
    @(negedge clk) bv = 0;
    chk(word == 16'h3344, "R2 burst second", word, 16'h3344);

    // R3 timeout
    idle(IDLE + 5);
    chk(sleep == 1 && led == 1, "R3 asleep after idle", sleep, 1);

    // R5 bytes ignored while asleep
    held = word;
    for (int i = 0; i < 4; i++) begin
      bv = 1; bdata = 8'h90 + 8'(i);
      @(negedge clk);
      chk(word_valid == 0 && word == held, "R5 ignored", word, held);
    end
    bv = 0;

    // R6 wake latency
    line = 1'b0;
    @(negedge clk) chk(sleep == 1, "R6 still asleep edge1", sleep, 1);
    @(negedge clk) chk(sleep == 1, "R6 still asleep edge2", sleep, 1);
    @(negedge clk) chk(sleep == 0, "R6 awake edge3", sleep, 0);
    // held low: no further activity, so timeout still runs
    idle(IDLE + 3);
    chk(sleep == 1, "R6 held low sleeps", sleep, 1);
    line = 1'b1;
    idle(2);

    // R7 half word discarded across sleep
    send_byte(8'hAA);
    idle(IDLE + 5);
    chk(sleep == 1, "R7 asleep with half word", sleep, 1);
    send_byte(8'h12);
    send_byte(8'h34);
    chk(word_valid == 1 && word == 16'h1234, "R7 fresh pair", word, 16'h1234);

    // R9 periodic activity keeps awake
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) line = 1'b0;
      @(negedge clk) line = 1'b1;
      idle(IDLE - 8);
      chk(sleep == 0, "R9 stays awake", sleep, 0);
    end
    idle(IDLE + 4);
    chk(sleep == 1, "R9 sleeps after last edge", sleep, 1);

    // R8 reset mid-pair and while asleep
    rst_n = 1'b0;
    @(negedge clk);
    chk(sleep == 0 && word == 0 && word_valid == 0, "R8 re-reset",
        {sleep, word_valid, word}, 0);
    rst_n = 1'b1;
    send_byte(8'h5A);
    send_byte(8'hC3);
    chk(word == 16'h5AC3, "R8 pair after reset", word, 16'h5AC3);
    idle(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule